// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the instruction fetch address of a processor that tracks two counters: the address of the instruction now executing (`fetch_pc`) and the address of the one after it (`next_pc`). Every retired instruction moves the second counter into the first. A control transfer only rewrites the second counter. As a result, the instruction that follows a branch, call or jump always runs before the target, and is called the delay slot. The sequencer also keeps a one-instruction squash state. Annulling branches use it to cancel their delay slot. An annulled instruction still advances the counters but has no effect of its own.

The decode stage gives the sequencer one retire strobe (`step`) and decoded control intent: conditional branch with its evaluated outcome, always-branch, annul bit, word-displacement call, register-indirect jump with its destination register, and trap entry. The sequencer returns the fetch address, a link-register write request and the squash flag. On a trap, it also returns a one-cycle save request that carries the interrupted pair of counters.

The control state machine has two states. `SEQ_RUN` is the normal state, in which the current instruction commits. `SEQ_SQUASH` means the current instruction is annulled. Its transitions are:
- ANNUL_SET, `SEQ_RUN` to `SEQ_SQUASH`: a retiring annulling branch requests a squash.
- SLOT_DONE, `SEQ_SQUASH` to `SEQ_RUN`: the annulled instruction retires.
- TRAP_CLEAR, any state to `SEQ_RUN`: a trap is taken.
- HOLD, no change: no retire and no trap.

When more than one control input is high, the first match in this order wins:
1. trap
2. call
3. register jump
4. always-branch
5. conditional branch

Top module: `pc_seq_top`

## Requirements
- R1: When an instruction retires with no transfer, `fetch_pc` takes the old `next_pc` and `next_pc` becomes the old `next_pc` plus 4, one clock after the retiring edge.
- R2: When a retiring conditional branch is taken (`br_cond`=1, `br_taken`=1) or an always-branch retires (`br_always`=1), `fetch_pc` takes the old `next_pc` (the delay slot) and `next_pc` takes `br_target`.
- R3: When a retiring conditional branch is not taken, `next_pc` increments by 4 as in R1.
- R4: A retiring call (`call_en`) loads `next_pc` with `fetch_pc + {call_disp, 2'b00}`. In the same cycle it raises `link_we` with `link_rd` = 15 and `link_val` = the address of the call.
- R5: A retiring register jump (`jmp_en`) loads `next_pc` with `jmp_base + jmp_ofs`. It raises `link_we` with `link_rd` = `jmp_rd` and `link_val` = the address of the jump. When `jmp_rd` = 0, `link_we` stays 0.
- R6: A return, which is a jump with `jmp_base` = a saved link value, `jmp_ofs` = 8 and `jmp_rd` = 0, continues at the instruction after the delay slot of the original call. This happens once the return's own delay slot has retired.
- R7: A retiring conditional branch with `annul`=1 that is not taken makes the next instruction annulled: `squash`=1 until that instruction retires. A taken conditional branch with `annul`=1 does not annul.
- R8: A retiring always-branch with `annul`=1 annuls its delay slot even though it is taken.
- R9: While `squash`=1, the instruction's control inputs are ignored. `link_we` stays 0, `next_pc` steps by 4, and no further squash is requested.
- R10: On `trap_en`, which needs no `step`, the next cycle shows `save_we`=1, `save_pc`/`save_npc` = the old `fetch_pc`/`next_pc`, `fetch_pc` = `trap_vec`, `next_pc` = `trap_vec`+4 and `squash`=0.
- R11: With `step`=0 and no trap, `fetch_pc`, `next_pc` and `squash` hold their values.
- R12: Reset gives `fetch_pc`=0, `next_pc`=4, `squash`=0 and `save_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Current instruction retires this cycle |
| br_cond | input | 1 | Current instruction is a conditional branch |
| br_taken | input | 1 | Evaluated condition of the conditional branch |
| br_always | input | 1 | Current instruction is an always-branch |
| annul | input | 1 | Annul bit of the branch |
| br_target | input | 32 | Branch target address |
| call_en | input | 1 | Current instruction is a displacement call |
| call_disp | input | 30 | Call word displacement |
| jmp_en | input | 1 | Current instruction is a register jump-and-link |
| jmp_base | input | 32 | Jump base register value |
| jmp_ofs | input | 32 | Jump offset |
| jmp_rd | input | 5 | Jump link destination register |
| trap_en | input | 1 | Trap entry |
| trap_vec | input | 32 | Trap vector address |
| fetch_pc | output | 32 | Address of the current instruction |
| next_pc | output | 32 | Address of the following instruction |
| squash | output | 1 | Current instruction is annulled |
| link_we | output | 1 | Link register write request |
| link_rd | output | 5 | Link destination register |
| link_val | output | 32 | Link value (address of the transfer) |
| save_we | output | 1 | One-cycle trap save request |
| save_pc | output | 32 | Interrupted `fetch_pc` |
| save_npc | output | 32 | Interrupted `next_pc` |

## Verification
The assertions check on every cycle that:
- the delay slot always follows a retire;
- a plain retire steps `next_pc` by 4;
- the counters hold when nothing retires;
- a trap loads the vector pair and clears the squash;
- a squash lasts exactly one retire and never allows a link write.

Only the bench's scenarios can show that the targets and link values are right. Those values depend on the data driven in. The same holds for the annul decision across the four branch/annul combinations, for a call followed by a return that lands after the call's delay slot, and for transfers ignored while annulled.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [0:0] {
        SEQ_RUN    = 1'b0,
        SEQ_SQUASH = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        XFER_NONE   = 3'd0,
        XFER_BRANCH = 3'd1,
        XFER_CALL   = 3'd2,
        XFER_JUMP   = 3'd3
    } xfer_e;

endpackage

// File: rtl/pcs_target.sv
module pcs_target
    import pcs_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 30
) (
    input  logic          active,
    input  logic [AW-1:0] cur_pc,
    input  logic          br_cond,
    input  logic          br_taken,
    input  logic          br_always,
    input  logic          annul,
    input  logic [AW-1:0] br_target,
    input  logic          call_en,
    input  logic [DW-1:0] call_disp,
    input  logic          jmp_en,
    input  logic [AW-1:0] jmp_base,
    input  logic [AW-1:0] jmp_ofs,
    output logic          redirect,
    output logic [AW-1:0] target,
    output logic          annul_req,
    output xfer_e         kind
);
    localparam int OFS_W = DW + 2;

    logic [OFS_W-1:0] call_ofs;
    logic [AW-1:0]    call_ofs_ext;

    assign call_ofs = {call_disp, 2'b00};

    generate
        if (OFS_W >= AW) begin : g_ofs_trunc
            assign call_ofs_ext = call_ofs[AW-1:0];
        end else begin : g_ofs_ext
            assign call_ofs_ext = {{(AW-OFS_W){1'b0}}, call_ofs};
        end
    endgenerate

    always_comb begin
        kind      = XFER_NONE;
        redirect  = 1'b0;
        target    = '0;
        annul_req = 1'b0;
        if (active) begin
            if (call_en) begin
                kind     = XFER_CALL;
                redirect = 1'b1;
                target   = cur_pc + call_ofs_ext;
            end else if (jmp_en) begin
                kind     = XFER_JUMP;
                redirect = 1'b1;
                target   = jmp_base + jmp_ofs;
            end else if (br_always) begin
                kind      = XFER_BRANCH;
                redirect  = 1'b1;
                target    = br_target;
                annul_req = annul;
            end else if (br_cond) begin
                kind = XFER_BRANCH;
                if (br_taken) begin
                    redirect = 1'b1;
                    target   = br_target;
                end else begin
                    annul_req = annul;
                end
            end
        end
    end

endmodule

// File: rtl/pcs_link.sv
module pcs_link
    import pcs_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RW       = 5,
    parameter int LINK_REG = 15
) (
    input  xfer_e         kind,
    input  logic [AW-1:0] cur_pc,
    input  logic [RW-1:0] jmp_rd,
    output logic          link_we,
    output logic [RW-1:0] link_rd,
    output logic [AW-1:0] link_val
);
    localparam logic [RW-1:0] CALL_RD = RW'(LINK_REG);

    always_comb begin
        link_val = cur_pc;
        unique case (kind)
            XFER_CALL: begin
                link_we = 1'b1;
                link_rd = CALL_RD;
            end
            XFER_JUMP: begin
                link_we = (jmp_rd != '0);
                link_rd = jmp_rd;
            end
            default: begin
                link_we = 1'b0;
                link_rd = '0;
            end
        endcase
    end

    always_comb begin
        AST_LINK_NONZERO: assert (!link_we || link_rd != '0); // R5
    end

endmodule

// File: rtl/pcs_annul_fsm.sv
module pcs_annul_fsm
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic trap_en,
    input  logic annul_req,
    output logic squash
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (trap_en) begin
            state_d = SEQ_RUN;
        end else if (step) begin
            unique case (state_q)
                SEQ_RUN:    state_d = annul_req ? SEQ_SQUASH : SEQ_RUN;
                SEQ_SQUASH: state_d = SEQ_RUN;
                default:    state_d = SEQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SEQ_SQUASH: squash = 1'b1;
            default:    squash = 1'b0;
        endcase
    end

    AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_en |=> (state_q == SEQ_RUN)); // R10
    AST_SQUASH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && step && !trap_en) |=> !squash); // R7

endmodule

// File: rtl/pc_seq_top.sv
module pc_seq_top
    import pcs_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 30,
    parameter int RW       = 5,
    parameter int LINK_REG = 15,
    parameter int RESET_PC = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          br_cond,
    input  logic          br_taken,
    input  logic          br_always,
    input  logic          annul,
    input  logic [AW-1:0] br_target,
    input  logic          call_en,
    input  logic [DW-1:0] call_disp,
    input  logic          jmp_en,
    input  logic [AW-1:0] jmp_base,
    input  logic [AW-1:0] jmp_ofs,
    input  logic [RW-1:0] jmp_rd,
    input  logic          trap_en,
    input  logic [AW-1:0] trap_vec,
    output logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] next_pc,
    output logic          squash,
    output logic          link_we,
    output logic [RW-1:0] link_rd,
    output logic [AW-1:0] link_val,
    output logic          save_we,
    output logic [AW-1:0] save_pc,
    output logic [AW-1:0] save_npc
);
    localparam logic [AW-1:0] STEP   = AW'(4);
    localparam logic [AW-1:0] RST_PC = AW'(RESET_PC);

    logic [AW-1:0] pc_q, npc_q, epc_q, enpc_q;
    logic          save_q;
    logic          active;
    logic          redirect;
    logic          annul_req;
    logic [AW-1:0] target;
    xfer_e         kind;

    assign active = step && !squash && !trap_en;

    pcs_target #(.AW(AW), .DW(DW)) u_target (
        .active    (active),
        .cur_pc    (pc_q),
        .br_cond   (br_cond),
        .br_taken  (br_taken),
        .br_always (br_always),
        .annul     (annul),
        .br_target (br_target),
        .call_en   (call_en),
        .call_disp (call_disp),
        .jmp_en    (jmp_en),
        .jmp_base  (jmp_base),
        .jmp_ofs   (jmp_ofs),
        .redirect  (redirect),
        .target    (target),
        .annul_req (annul_req),
        .kind      (kind)
    );

    pcs_link #(.AW(AW), .RW(RW), .LINK_REG(LINK_REG)) u_link (
        .kind     (kind),
        .cur_pc   (pc_q),
        .jmp_rd   (jmp_rd),
        .link_we  (link_we),
        .link_rd  (link_rd),
        .link_val (link_val)
    );

    pcs_annul_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .trap_en   (trap_en),
        .annul_req (annul_req),
        .squash    (squash)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= RST_PC;
            npc_q  <= RST_PC + STEP;
            epc_q  <= '0;
            enpc_q <= '0;
            save_q <= 1'b0;
        end else if (trap_en) begin
            epc_q  <= pc_q;
            enpc_q <= npc_q;
            save_q <= 1'b1;
            pc_q   <= trap_vec;
            npc_q  <= trap_vec + STEP;
        end else begin
            save_q <= 1'b0;
            if (step) begin
                pc_q  <= npc_q;
                npc_q <= redirect ? target : (npc_q + STEP);
            end
        end
    end

    assign fetch_pc = pc_q;
    assign next_pc  = npc_q;
    assign save_we  = save_q;
    assign save_pc  = epc_q;
    assign save_npc = enpc_q;

    AST_DELAY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !trap_en) |=> (fetch_pc == $past(next_pc))); // R2
    AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !trap_en && !redirect) |=> (next_pc == $past(next_pc) + STEP)); // R1
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !trap_en) |=> ($stable(fetch_pc) && $stable(next_pc) && $stable(squash))); // R11
    AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        trap_en |=> (save_we && next_pc == fetch_pc + STEP && save_pc == $past(fetch_pc))); // R10
    AST_SQUASH_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> !link_we); // R9

endmodule

// File: tb/tb_pc_seq_top.sv
module tb_pc_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 0, br_cond = 0, br_taken = 0, br_always = 0, annul = 0;
    logic [31:0] br_target = 0;
    logic        call_en = 0;
    logic [29:0] call_disp = 0;
    logic        jmp_en = 0;
    logic [31:0] jmp_base = 0, jmp_ofs = 0;
    logic [4:0]  jmp_rd = 0;
    logic        trap_en = 0;
    logic [31:0] trap_vec = 0;
    logic [31:0] fetch_pc, next_pc, link_val, save_pc, save_npc;
    logic        squash, link_we, save_we;
    logic [4:0]  link_rd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_pc, m_npc, m_epc, m_enpc;
    logic        m_sq, m_sw;
    logic [31:0] saved_link;

    always #10 clk = ~clk;

    pc_seq_top dut (
        .clk(clk), .rst_n(rst_n), .step(step), .br_cond(br_cond), .br_taken(br_taken),
        .br_always(br_always), .annul(annul), .br_target(br_target), .call_en(call_en),
        .call_disp(call_disp), .jmp_en(jmp_en), .jmp_base(jmp_base), .jmp_ofs(jmp_ofs),
        .jmp_rd(jmp_rd), .trap_en(trap_en), .trap_vec(trap_vec), .fetch_pc(fetch_pc),
        .next_pc(next_pc), .squash(squash), .link_we(link_we), .link_rd(link_rd),
        .link_val(link_val), .save_we(save_we), .save_pc(save_pc), .save_npc(save_npc)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        step = 0; br_cond = 0; br_taken = 0; br_always = 0; annul = 0;
        call_en = 0; jmp_en = 0; jmp_rd = 0; trap_en = 0;
    endtask

    // one clock: inputs already driven after a falling edge
    task automatic tick(input string tag);
        logic        e_we;
        logic [4:0]  e_rd;
        logic        redir, nsq;
        logic [31:0] tgt;
        #1;
        e_we = 0; e_rd = 0;
        if (step && !m_sq && !trap_en) begin
            if (call_en) begin e_we = 1; e_rd = 5'd15; end
            else if (jmp_en && jmp_rd != 0) begin e_we = 1; e_rd = jmp_rd; end
        end
        chk(tag, "link_we", {31'b0, link_we}, {31'b0, e_we});
        if (e_we) begin
            chk(tag, "link_rd", {27'b0, link_rd}, {27'b0, e_rd});
            chk(tag, "link_val", link_val, m_pc);
        end
        @(posedge clk);
        if (trap_en) begin
            m_epc = m_pc; m_enpc = m_npc; m_sw = 1;
            m_pc = trap_vec; m_npc = trap_vec + 4; m_sq = 0;
        end else begin
            m_sw = 0;
            if (step) begin
                redir = 0; nsq = 0; tgt = 0;
                if (!m_sq) begin
                    if (call_en) begin redir = 1; tgt = m_pc + {call_disp, 2'b00}; end
                    else if (jmp_en) begin redir = 1; tgt = jmp_base + jmp_ofs; end
                    else if (br_always) begin redir = 1; tgt = br_target; nsq = annul; end
                    else if (br_cond) begin
                        if (br_taken) begin redir = 1; tgt = br_target; end
                        else nsq = annul;
                    end
                end
                m_pc = m_npc;
                m_npc = redir ? tgt : m_npc + 4;
                m_sq = nsq;
            end
        end
        @(negedge clk);
        chk(tag, "fetch_pc", fetch_pc, m_pc);
        chk(tag, "next_pc", next_pc, m_npc);
        chk(tag, "squash", {31'b0, squash}, {31'b0, m_sq});
        chk(tag, "save_we", {31'b0, save_we}, {31'b0, m_sw});
        if (m_sw) begin
            chk(tag, "save_pc", save_pc, m_epc);
            chk(tag, "save_npc", save_npc, m_enpc);
        end
        clear_in();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_pc = 0; m_npc = 4; m_sq = 0; m_sw = 0; m_epc = 0; m_enpc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        chk("R12", "fetch_pc", fetch_pc, 32'h0);
        chk("R12", "next_pc", next_pc, 32'h4);
        chk("R12", "squash", {31'b0, squash}, 32'h0);
        chk("R12", "save_we", {31'b0, save_we}, 32'h0);

        // R1 plain retires
        for (int i = 0; i < 3; i++) begin step = 1; tick("R1"); end
        // R11 hold
        tick("R11");
        tick("R11");
        // R3 conditional not taken
        step = 1; br_cond = 1; br_taken = 0; br_target = 32'h400; tick("R3");
        // R2 conditional taken, delay slot then target
        step = 1; br_cond = 1; br_taken = 1; br_target = 32'h100; tick("R2");
        step = 1; tick("R2");
        chk("R2", "at target", fetch_pc, 32'h100);
        // R2 always-branch without annul
        step = 1; br_always = 1; br_target = 32'h200; tick("R2");
        step = 1; tick("R2");

        // R4 call, R6 return
        saved_link = m_pc;
        step = 1; call_en = 1; call_disp = 30'h40; tick("R4");
        step = 1; tick("R4");
        chk("R4", "call target", fetch_pc, saved_link + 32'h100);
        step = 1; tick("R6");
        step = 1; jmp_en = 1; jmp_base = saved_link; jmp_ofs = 8; jmp_rd = 0; tick("R6");
        step = 1; tick("R6");
        chk("R6", "return lands", fetch_pc, saved_link + 8);

        // R5 register jump with link, and to r0
        step = 1; jmp_en = 1; jmp_base = 32'h2000; jmp_ofs = 32'h10; jmp_rd = 5'd7; tick("R5");
        step = 1; tick("R5");
        chk("R5", "jump target", fetch_pc, 32'h2010);
        step = 1; jmp_en = 1; jmp_base = 32'h3000; jmp_ofs = 0; jmp_rd = 0; tick("R5");
        step = 1; tick("R5");

        // R7 annul on not-taken, then no annul when taken
        step = 1; br_cond = 1; br_taken = 0; annul = 1; tick("R7");
        chk("R7", "squash set", {31'b0, squash}, 32'h1);
        tick("R7");
        step = 1; tick("R7");
        step = 1; br_cond = 1; br_taken = 1; annul = 1; br_target = 32'h600; tick("R7");
        chk("R7", "taken no squash", {31'b0, squash}, 32'h0);
        step = 1; tick("R7");

        // R8 always-branch with annul
        step = 1; br_always = 1; annul = 1; br_target = 32'h800; tick("R8");
        chk("R8", "squash set", {31'b0, squash}, 32'h1);
        // R9 annulled call ignored
        step = 1; call_en = 1; call_disp = 30'h1000; tick("R9");
        chk("R9", "not redirected", next_pc, 32'h804);
        chk("R8", "at target", fetch_pc, 32'h800);
        step = 1; tick("R9");

        // R10 trap, also from squash state
        trap_en = 1; trap_vec = 32'h40; tick("R10");
        step = 1; tick("R10");
        step = 1; br_always = 1; annul = 1; br_target = 32'h900; tick("R10");
        trap_en = 1; trap_vec = 32'h80; tick("R10");
        chk("R10", "vector pc", fetch_pc, 32'h80);
        step = 1; tick("R1");
        step = 1; tick("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule